// File: doc/BRIEF.md
# Flat Address Aperture Resolver

This block takes one vector memory instruction whose lanes carry 64-bit flat virtual addresses, together with the mask of active lanes. It works out which memory segment the instruction targets: local shared memory (group), per-lane scratch (private), or global memory.

The lowest-numbered active lane decides the segment by testing a fixed series of address windows. Every other active lane must agree with that choice. Each active lane's address is then rewritten into its segment-relative form. The result reports the segment, the execution unit that should carry the access, and which outstanding-request counters the issuing wavefront may now release.

A single error flag covers every illegal case:
- an address in the unsupported virtual-memory window,
- an address in the non-canonical hole,
- lanes that disagree on the segment,
- a local-memory overrun,
- an empty mask,
- an unknown operation.

Window bounds, the local-memory size and the per-wavefront scratch parameters arrive as inputs. The block is used in the issue path of a compute unit, after address generation and before the memory pipelines.

Top module: `fa_resolver`

## Requirements
- R1: A request accepted when `in_valid_i` and `in_ready_o` are both high produces its result with `out_valid_o` high in the following cycle. `in_ready_o` equals `!out_valid_o || out_ready_i`. While `out_valid_o` is high and `out_ready_i` is low, every output holds its value.
- R2: The class of an address comes from the first test that matches, in this order:
  - the local window `[lds_lo_i, lds_hi_i]` gives group;
  - the scratch window `[scr_lo_i, scr_hi_i]` gives private;
  - the virtual-memory window `[vm_lo_i, vm_hi_i]` is an error;
  - the hole test of R3 is an error;
  - anything else is global.
  
  All bounds are inclusive. The segment is the class of the lowest-numbered active lane. `out_seg_o` encodes 0 as none, 1 as global, 2 as group and 3 as private. It reads none when the mask is empty or the leading lane hits the virtual-memory window or the hole.
- R3: An address is in the hole when bits [63:47] are neither all zeros nor all ones. Such an address on the leading lane raises `out_err_o`.
- R4: Every active lane must have the same class as the leading lane, or `out_err_o` is raised. Inactive lanes take no part in classification or in this check.
- R5: Under the group segment, each active lane outputs its address minus `lds_lo_i`. A result not below `lds_size_i` raises `out_err_o`.
- R6: Under the private segment, active lane i outputs addr + i*`priv_stride_i` + `priv_offset_i` + `priv_hidden_base_i` - `priv_scratch_base_i`, computed modulo 2^64.
- R7: Under the global segment, addresses pass unchanged and `out_unit_o` is 0 (global-memory unit). Under group or private, `out_unit_o` is 1 (local-memory unit).
- R8: `in_op_i` encodes 1 as load, 2 as store, 3 as atomic and 4 as sync. Loads release the read counter, stores the write counter, and atomics and syncs release both. Global releases the local-memory pipe counters (`rel_lm_*`). Group and private release the global-memory pipe counters (`rel_gm_*`).
- R9: Group additionally pulses `dec_vmem_o`. Private additionally pulses `dec_lgkm_o`.
- R10: An empty active mask, or an `in_op_i` outside 1..4, raises `out_err_o`. Whenever `out_err_o` is high, every release and decrement output is low.
- R11: Inactive lanes, and all lanes when the segment is none, output their input address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| in_addr_i | input | NUM_LANES*64 | Flat address per lane, lane i at bits [64i+63:64i] |
| in_mask_i | input | NUM_LANES | Active-lane mask |
| in_op_i | input | 3 | Operation kind |
| lds_lo_i | input | 64 | Local window low bound |
| lds_hi_i | input | 64 | Local window high bound |
| lds_size_i | input | 32 | Local memory size in bytes |
| scr_lo_i | input | 64 | Scratch window low bound |
| scr_hi_i | input | 64 | Scratch window high bound |
| vm_lo_i | input | 64 | Unsupported window low bound |
| vm_hi_i | input | 64 | Unsupported window high bound |
| priv_offset_i | input | 32 | Per-wavefront scratch offset |
| priv_stride_i | input | 32 | Per-lane scratch stride |
| priv_hidden_base_i | input | 64 | Hidden private base added |
| priv_scratch_base_i | input | 64 | Scratch base subtracted |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result consumed |
| out_seg_o | output | 2 | Resolved segment |
| out_unit_o | output | 1 | 0 global-memory unit, 1 local-memory unit |
| out_addr_o | output | NUM_LANES*64 | Segment-relative address per lane |
| out_err_o | output | 1 | Violation flag |
| rel_gm_rd_o | output | 1 | Release global pipe read counter |
| rel_gm_wr_o | output | 1 | Release global pipe write counter |
| rel_lm_rd_o | output | 1 | Release local pipe read counter |
| rel_lm_wr_o | output | 1 | Release local pipe write counter |
| dec_vmem_o | output | 1 | Decrement vector-memory issued count |
| dec_lgkm_o | output | 1 | Decrement scalar/local issued count |

## Verification
Several properties are checked on every cycle:
- the output stays frozen under backpressure;
- an error never comes with a counter release;
- an empty mask always turns into an error one cycle later;
- the two extra decrements never fire together;
- a global result never touches the global-pipe counters or the extra decrements;
- a good group or private result always picks the local unit.

The address arithmetic, the window priority and the inclusive bounds, the hole edges, the rule that inactive lanes are ignored, and the local overrun can only be shown by the bench. It does this with directed scenarios and with random lane mixes compared against its own model.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    SEG_NONE    = 2'd0,
    SEG_GLOBAL  = 2'd1,
    SEG_GROUP   = 2'd2,
    SEG_PRIVATE = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    CLS_GROUP   = 3'd0,
    CLS_PRIVATE = 3'd1,
    CLS_VM      = 3'd2,
    CLS_HOLE    = 3'd3,
    CLS_GLOBAL  = 3'd4
  } cls_e;

  localparam logic [2:0] OP_LOAD   = 3'd1;
  localparam logic [2:0] OP_STORE  = 3'd2;
  localparam logic [2:0] OP_ATOMIC = 3'd3;
  localparam logic [2:0] OP_SYNC   = 3'd4;

  function automatic seg_e seg_of(input cls_e c);
    case (c)
      CLS_GROUP:   return SEG_GROUP;
      CLS_PRIVATE: return SEG_PRIVATE;
      CLS_GLOBAL:  return SEG_GLOBAL;
      default:     return SEG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fa_lane_classify.sv
module fa_lane_classify
  import fa_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int HOLE_LSB = 47
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lds_lo_i,
  input  logic [ADDR_W-1:0] lds_hi_i,
  input  logic [ADDR_W-1:0] scr_lo_i,
  input  logic [ADDR_W-1:0] scr_hi_i,
  input  logic [ADDR_W-1:0] vm_lo_i,
  input  logic [ADDR_W-1:0] vm_hi_i,
  output cls_e              cls_o
);
  localparam int HI_W = ADDR_W - HOLE_LSB;

  logic [HI_W-1:0] hi_bits;
  logic in_lds, in_scr, in_vm, in_hole;

  assign hi_bits = addr_i[ADDR_W-1:HOLE_LSB];
  assign in_lds  = (addr_i >= lds_lo_i) && (addr_i <= lds_hi_i);
  assign in_scr  = (addr_i >= scr_lo_i) && (addr_i <= scr_hi_i);
  assign in_vm   = (addr_i >= vm_lo_i)  && (addr_i <= vm_hi_i);
  assign in_hole = (|hi_bits) && !(&hi_bits);

  always_comb begin
    if (in_lds)       cls_o = CLS_GROUP;
    else if (in_scr)  cls_o = CLS_PRIVATE;
    else if (in_vm)   cls_o = CLS_VM;
    else if (in_hole) cls_o = CLS_HOLE;
    else              cls_o = CLS_GLOBAL;
  end
endmodule

// File: rtl/fa_lead_select.sv
module fa_lead_select
  import fa_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0] mask_i,
  input  cls_e [NUM_LANES-1:0] cls_i,
  output logic                 found_o,
  output cls_e                 lead_o,
  output logic                 mismatch_o
);
  always_comb begin
    lead_o = CLS_GLOBAL;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (mask_i[i]) lead_o = cls_i[i];
    end
  end

  always_comb begin
    mismatch_o = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (mask_i[i] && (cls_i[i] != lead_o)) mismatch_o = 1'b1;
    end
  end

  assign found_o = |mask_i;
endmodule

// File: rtl/fa_lane_xlate.sv
module fa_lane_xlate
  import fa_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int CFG_W    = 32,
  parameter int LANE_IDX = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              active_i,
  input  seg_e              seg_i,
  input  logic [ADDR_W-1:0] lds_lo_i,
  input  logic [CFG_W-1:0]  lds_size_i,
  input  logic [CFG_W-1:0]  priv_offset_i,
  input  logic [CFG_W-1:0]  priv_stride_i,
  input  logic [ADDR_W-1:0] priv_hidden_base_i,
  input  logic [ADDR_W-1:0] priv_scratch_base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bound_err_o
);
  localparam logic [ADDR_W-1:0] LANE_NUM = ADDR_W'(LANE_IDX);

  logic [ADDR_W-1:0] lds_rel, priv_addr;

  assign lds_rel   = addr_i - lds_lo_i;
  assign priv_addr = addr_i + LANE_NUM * ADDR_W'(priv_stride_i) + ADDR_W'(priv_offset_i)
                   + priv_hidden_base_i - priv_scratch_base_i;

  always_comb begin
    addr_o = addr_i;
    if (active_i) begin
      case (seg_i)
        SEG_GROUP:   addr_o = lds_rel;
        SEG_PRIVATE: addr_o = priv_addr;
        default:     addr_o = addr_i;
      endcase
    end
  end

  assign bound_err_o = active_i && (seg_i == SEG_GROUP) && !(lds_rel < ADDR_W'(lds_size_i));
endmodule

// File: rtl/fa_resolver.sv
module fa_resolver
  import fa_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int ADDR_W    = 64,
  parameter int CFG_W     = 32,
  parameter int HOLE_LSB  = 47
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [NUM_LANES*ADDR_W-1:0]   in_addr_i,
  input  logic [NUM_LANES-1:0]          in_mask_i,
  input  logic [2:0]                    in_op_i,
  input  logic [ADDR_W-1:0]             lds_lo_i,
  input  logic [ADDR_W-1:0]             lds_hi_i,
  input  logic [CFG_W-1:0]              lds_size_i,
  input  logic [ADDR_W-1:0]             scr_lo_i,
  input  logic [ADDR_W-1:0]             scr_hi_i,
  input  logic [ADDR_W-1:0]             vm_lo_i,
  input  logic [ADDR_W-1:0]             vm_hi_i,
  input  logic [CFG_W-1:0]              priv_offset_i,
  input  logic [CFG_W-1:0]              priv_stride_i,
  input  logic [ADDR_W-1:0]             priv_hidden_base_i,
  input  logic [ADDR_W-1:0]             priv_scratch_base_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [1:0]                    out_seg_o,
  output logic                          out_unit_o,
  output logic [NUM_LANES*ADDR_W-1:0]   out_addr_o,
  output logic                          out_err_o,
  output logic                          rel_gm_rd_o,
  output logic                          rel_gm_wr_o,
  output logic                          rel_lm_rd_o,
  output logic                          rel_lm_wr_o,
  output logic                          dec_vmem_o,
  output logic                          dec_lgkm_o
);
  localparam int VEC_W = NUM_LANES * ADDR_W;

  cls_e [NUM_LANES-1:0] lane_cls;
  logic [NUM_LANES-1:0] lane_bound_err;
  logic [VEC_W-1:0]     xl_addr;
  logic                 lead_found, lane_mismatch;
  cls_e                 lead_cls;
  seg_e                 seg_d;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fa_lane_classify #(.ADDR_W(ADDR_W), .HOLE_LSB(HOLE_LSB)) u_cls (
      .addr_i   (in_addr_i[g*ADDR_W +: ADDR_W]),
      .lds_lo_i (lds_lo_i),
      .lds_hi_i (lds_hi_i),
      .scr_lo_i (scr_lo_i),
      .scr_hi_i (scr_hi_i),
      .vm_lo_i  (vm_lo_i),
      .vm_hi_i  (vm_hi_i),
      .cls_o    (lane_cls[g])
    );

    fa_lane_xlate #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .LANE_IDX(g)) u_xl (
      .addr_i              (in_addr_i[g*ADDR_W +: ADDR_W]),
      .active_i            (in_mask_i[g]),
      .seg_i               (seg_d),
      .lds_lo_i            (lds_lo_i),
      .lds_size_i          (lds_size_i),
      .priv_offset_i       (priv_offset_i),
      .priv_stride_i       (priv_stride_i),
      .priv_hidden_base_i  (priv_hidden_base_i),
      .priv_scratch_base_i (priv_scratch_base_i),
      .addr_o              (xl_addr[g*ADDR_W +: ADDR_W]),
      .bound_err_o         (lane_bound_err[g])
    );
  end

  fa_lead_select #(.NUM_LANES(NUM_LANES)) u_lead (
    .mask_i     (in_mask_i),
    .cls_i      (lane_cls),
    .found_o    (lead_found),
    .lead_o     (lead_cls),
    .mismatch_o (lane_mismatch)
  );

  assign seg_d = lead_found ? seg_of(lead_cls) : SEG_NONE;

  logic op_rd, op_wr, op_bad, err_d, unit_d;
  logic gm_rd_d, gm_wr_d, lm_rd_d, lm_wr_d, vmem_d, lgkm_d;

  assign op_rd  = (in_op_i == OP_LOAD)  || (in_op_i == OP_ATOMIC) || (in_op_i == OP_SYNC);
  assign op_wr  = (in_op_i == OP_STORE) || (in_op_i == OP_ATOMIC) || (in_op_i == OP_SYNC);
  assign op_bad = !(op_rd || op_wr);

  assign err_d  = (seg_d == SEG_NONE) || lane_mismatch || (|lane_bound_err) || op_bad;
  assign unit_d = (seg_d == SEG_GROUP) || (seg_d == SEG_PRIVATE);

  always_comb begin
    gm_rd_d = 1'b0; gm_wr_d = 1'b0; lm_rd_d = 1'b0; lm_wr_d = 1'b0;
    vmem_d  = 1'b0; lgkm_d  = 1'b0;
    if (!err_d) begin
      case (seg_d)
        SEG_GLOBAL: begin
          lm_rd_d = op_rd; lm_wr_d = op_wr;
        end
        SEG_GROUP: begin
          gm_rd_d = op_rd; gm_wr_d = op_wr; vmem_d = 1'b1;
        end
        SEG_PRIVATE: begin
          gm_rd_d = op_rd; gm_wr_d = op_wr; lgkm_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_seg_o   <= SEG_NONE;
      out_unit_o  <= 1'b0;
      out_addr_o  <= '0;
      out_err_o   <= 1'b0;
      rel_gm_rd_o <= 1'b0;
      rel_gm_wr_o <= 1'b0;
      rel_lm_rd_o <= 1'b0;
      rel_lm_wr_o <= 1'b0;
      dec_vmem_o  <= 1'b0;
      dec_lgkm_o  <= 1'b0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (in_valid_i && in_ready_o) begin
        out_seg_o   <= seg_d;
        out_unit_o  <= unit_d;
        out_addr_o  <= xl_addr;
        out_err_o   <= err_d;
        rel_gm_rd_o <= gm_rd_d;
        rel_gm_wr_o <= gm_wr_d;
        rel_lm_rd_o <= lm_rd_d;
        rel_lm_wr_o <= lm_wr_d;
        dec_vmem_o  <= vmem_d;
        dec_lgkm_o  <= lgkm_d;
      end
    end
  end

  // R1: stalled result stays put
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o) && $stable(out_err_o)
                                    && $stable(out_seg_o));

  // R10: errors release nothing
  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_o |-> !(rel_gm_rd_o || rel_gm_wr_o || rel_lm_rd_o || rel_lm_wr_o
                                   || dec_vmem_o || dec_lgkm_o));

  // R10: empty mask is an error one cycle later
  a_r10_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_mask_i == '0) |=> out_valid_o && out_err_o);

  // R9: at most one extra decrement
  a_r9_one_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot0({dec_vmem_o, dec_lgkm_o}));

  // R8: global touches only local-pipe counters
  a_r8_global_lm_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_seg_o == SEG_GLOBAL) |-> !rel_gm_rd_o && !rel_gm_wr_o && !dec_vmem_o
                                                 && !dec_lgkm_o);

  // R7: local segments pick the local unit
  a_r7_local_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_err_o && (dec_vmem_o || dec_lgkm_o) |-> out_unit_o);
endmodule

// File: tb/fa_resolver_bench.sv
`timescale 1ns/1ps
module fa_resolver_bench;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             in_valid = 1'b0, in_ready;
  logic [NL*64-1:0] in_addr = '0;
  logic [NL-1:0]    in_mask = '0;
  logic [2:0]       in_op = 3'd1;
  logic [63:0] lds_lo = 64'h0000_1000_0000_0000, lds_hi = 64'h0000_1000_FFFF_FFFF;
  logic [63:0] scr_lo = 64'h0000_2000_0000_0000, scr_hi = 64'h0000_2000_FFFF_FFFF;
  logic [63:0] vm_lo  = 64'h0000_3000_0000_0000, vm_hi  = 64'h0000_3000_FFFF_FFFF;
  logic [31:0] lds_size = 32'h0001_0000;
  logic [31:0] p_off = 32'h0000_0100, p_stride = 32'h0000_0400;
  logic [63:0] p_hidden = 64'h0000_0800_0000_0000, p_sbase = 64'h0000_0400_0000_0000;
  logic             out_valid, out_ready = 1'b1;
  logic [1:0]       out_seg;
  logic             out_unit, out_err;
  logic [NL*64-1:0] out_addr;
  logic gm_rd, gm_wr, lm_rd, lm_wr, d_vmem, d_lgkm;

  fa_resolver #(.NUM_LANES(NL)) u_fa_resolver (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_addr_i(in_addr), .in_mask_i(in_mask), .in_op_i(in_op),
    .lds_lo_i(lds_lo), .lds_hi_i(lds_hi), .lds_size_i(lds_size),
    .scr_lo_i(scr_lo), .scr_hi_i(scr_hi), .vm_lo_i(vm_lo), .vm_hi_i(vm_hi),
    .priv_offset_i(p_off), .priv_stride_i(p_stride),
    .priv_hidden_base_i(p_hidden), .priv_scratch_base_i(p_sbase),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_seg_o(out_seg),
    .out_unit_o(out_unit), .out_addr_o(out_addr), .out_err_o(out_err),
    .rel_gm_rd_o(gm_rd), .rel_gm_wr_o(gm_wr), .rel_lm_rd_o(lm_rd), .rel_lm_wr_o(lm_wr),
    .dec_vmem_o(d_vmem), .dec_lgkm_o(d_lgkm));

  int checks = 0, errors = 0;
  logic [63:0] la [NL];
  logic [9:0]       exp_ctl;
  logic [NL*64-1:0] exp_addr;

  // class codes: 0 group, 1 private, 2 vm, 3 hole, 4 global
  function automatic int cls_of(input logic [63:0] a);
    if (a >= lds_lo && a <= lds_hi) return 0;
    if (a >= scr_lo && a <= scr_hi) return 1;
    if (a >= vm_lo && a <= vm_hi) return 2;
    if (a[63:47] != 17'h0 && a[63:47] != 17'h1FFFF) return 3;
    return 4;
  endfunction

  task automatic model();
    int lead = -1;
    logic err, rd, wr, unit;
    logic [1:0] seg;
    logic [5:0] rel;
    for (int i = 0; i < NL; i++) in_addr[i*64 +: 64] = la[i];
    for (int i = NL - 1; i >= 0; i--) if (in_mask[i]) lead = cls_of(la[i]);
    rd = (in_op == 3'd1) || (in_op == 3'd3) || (in_op == 3'd4);
    wr = (in_op == 3'd2) || (in_op == 3'd3) || (in_op == 3'd4);
    case (lead)
      0: seg = 2'd2;
      1: seg = 2'd3;
      4: seg = 2'd1;
      default: seg = 2'd0;
    endcase
    err = (seg == 2'd0) || !(rd || wr);
    for (int i = 0; i < NL; i++) begin
      exp_addr[i*64 +: 64] = la[i];
      if (in_mask[i]) begin
        if (cls_of(la[i]) != lead) err = 1'b1;
        if (seg == 2'd2) begin
          exp_addr[i*64 +: 64] = la[i] - lds_lo;
          if (la[i] - lds_lo >= {32'h0, lds_size}) err = 1'b1;
        end else if (seg == 2'd3) begin
          exp_addr[i*64 +: 64] = la[i] + 64'(i) * {32'h0, p_stride} + {32'h0, p_off}
                                 + p_hidden - p_sbase;
        end
      end
    end
    unit = (seg == 2'd2) || (seg == 2'd3);
    rel = '0; // gm_rd gm_wr lm_rd lm_wr vmem lgkm
    if (!err) begin
      if (seg == 2'd1) rel = {2'b00, rd, wr, 2'b00};
      else rel = {rd, wr, 2'b00, seg == 2'd2, seg == 2'd3};
    end
    exp_ctl = {1'b1, seg, unit, err, rel};
  endtask

  task automatic check_out(input string tag);
    logic [9:0] got;
    got = {out_valid, out_seg, out_unit, out_err, gm_rd, gm_wr, lm_rd, lm_wr, d_vmem, d_lgkm};
    checks++;
    if (got !== exp_ctl || out_addr !== exp_addr) begin
      errors++;
      $display("FAIL %s: ctl got %b exp %b addr got %h exp %h", tag, got, exp_ctl,
               out_addr, exp_addr);
    end
  endtask

  task automatic send(input string tag);
    @(negedge clk);
    model();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag);
  endtask

  task automatic set4(input logic [63:0] a0, a1, a2, a3, input logic [3:0] m,
                      input logic [2:0] op);
    la[0] = a0; la[1] = a1; la[2] = a2; la[3] = a3; in_mask = m; in_op = op;
  endtask

  function automatic logic [63:0] gen(input int k);
    logic [63:0] r = {$urandom, $urandom};
    case (k)
      0: return lds_lo + 64'($urandom % 32'h12000);
      1: return scr_lo + 64'(r[31:0]);
      2: return vm_lo + 64'(r[31:0]);
      3: return {8'h01, r[55:0]};
      default: return r[0] ? {17'h0, r[46:0]} : {17'h1FFFF, r[46:0]};
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231010));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL reset R1: valid/ready got %b%b exp 01", out_valid, in_ready);
    end
    rst_n = 1'b1;

    set4(64'h10, 64'h20, 64'hFFFF_8000_0000_0040, 64'h7FFF_FFFF_FFF0, 4'hF, 3'd1);
    send("R7 R8 global load");
    set4(lds_lo, lds_lo + 64'h100, lds_lo + 64'hFFFF, lds_lo + 64'h8, 4'hF, 3'd2);
    send("R5 R9 group store");
    set4(lds_lo, lds_lo + 64'h10000, lds_lo, lds_lo, 4'hF, 3'd1);
    send("R5 group overrun");
    set4(scr_lo, scr_lo + 64'h4, scr_lo + 64'h8, scr_lo + 64'hC, 4'hF, 3'd3);
    send("R6 R9 private atomic");
    set4(vm_lo, 64'h1_0000_0000_0000, 64'h40, 64'h80, 4'b1100, 3'd4);
    send("R4 R11 inactive lanes ignored, sync R8");
    set4(vm_lo + 64'h5, 64'h40, 64'h40, 64'h40, 4'b0001, 3'd1);
    send("R2 virtual window error");
    set4(64'h0000_8000_0000_0000, 64'h40, 64'h40, 64'h40, 4'b0011, 3'd1);
    send("R3 hole lead");
    set4(64'hFFFF_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0000, 64'h0000_7FFF_FFFF_FFFF, 64'h0,
         4'b0001, 3'd2);
    send("R3 hole edge");
    set4(64'hFFFF_8000_0000_0000, 64'h0000_7FFF_FFFF_FFFF, 64'h0, 64'h8, 4'hF, 3'd2);
    send("R3 canonical edges global");
    set4(lds_hi, lds_hi, lds_hi, lds_hi, 4'b0001, 3'd1);
    send("R2 window high bound inclusive");
    set4(lds_hi + 64'h1, lds_lo - 64'h1, 64'h0, 64'h0, 4'b0011, 3'd1);
    send("R2 just outside window");
    scr_lo = lds_lo; scr_hi = lds_hi;
    set4(lds_lo + 64'h20, lds_lo + 64'h40, 64'h0, 64'h0, 4'b0011, 3'd1);
    send("R2 local window wins over scratch");
    scr_lo = 64'h0000_2000_0000_0000; scr_hi = 64'h0000_2000_FFFF_FFFF;
    set4(64'h100, lds_lo, 64'h0, 64'h0, 4'b0011, 3'd1);
    send("R4 lane mismatch");
    set4(64'h100, 64'h200, 64'h0, 64'h0, 4'b0000, 3'd1);
    send("R10 empty mask");
    set4(64'h100, 64'h200, 64'h0, 64'h0, 4'b0011, 3'd0);
    send("R10 bad op");
    set4(scr_lo, scr_lo, scr_lo, scr_lo, 4'b1010, 3'd6);
    send("R10 bad op private");

    // R1 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    set4(lds_lo + 64'h10, lds_lo + 64'h20, 64'h0, 64'h0, 4'b0011, 3'd2);
    model();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set4(64'h300, 64'h400, 64'h500, 64'h600, 4'hF, 3'd1);
    for (int i = 0; i < NL; i++) in_addr[i*64 +: 64] = la[i];
    check_out("R1 first result");
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 ready under stall: got %b exp 0", in_ready);
    end
    repeat (2) @(negedge clk);
    check_out("R1 held under stall");
    out_ready = 1'b1;
    model();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R1 second result after release");

    for (int n = 0; n < 400; n++) begin
      int k0 = int'($urandom % 5);
      for (int i = 0; i < NL; i++)
        la[i] = gen(($urandom % 4 != 0) ? k0 : int'($urandom % 5));
      in_mask = 4'($urandom);
      in_op = ($urandom % 8 == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
      send("RAND R2 R4 R5 R6 R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule